// File: doc/BRIEF.md
# Event Record Stream Unpacker

This block walks a list of event records that sits in a word-wide memory. A single pulse on `en_set` starts it at a word address given on `base_addr`. It then reads consecutive memory words through a request/acknowledge port and keeps the bytes in a byte-granular holding buffer. Because of this buffer, a record may start at any byte lane and may run into the following word. Each complete record is split into its fields and placed in an output register behind a valid/ready handshake.

The byte stream is little-endian throughout. Stream byte k sits in word `base_addr + k/WB`, in lane `k % WB`, which is bits `8*(k%WB)` upward. A record starts with a length byte L, which counts the whole record including itself. Next come the channel (3 bytes), the timestamp (8 bytes), the target address (2 bytes) and the payload (L-14 bytes, 1 to 64). Every multi-byte field is little-endian.

A length byte of zero ends the list. A length outside 15..78 raises a sticky error flag and also ends the list. In both cases `busy` drops, and software can start the block again.

Top module: `evrec_unpack`

## Requirements
- R1: While reset is applied and after it is released, `busy`, `err`, `ev_valid` and `mem_req` are all 0.
- R2: An `en_set` pulse while `busy` is 0 makes `busy` 1 and `err` 0 on the next cycle, with `mem_addr` equal to `base_addr`. After that, `mem_addr` advances by one for every cycle in which `mem_req` and `mem_ack` are both high. `mem_req` is high only while `busy` is 1.
- R3: For each record, `ev_channel`, `ev_time` and `ev_addr` carry the 3, 8 and 2 little-endian bytes that follow the length byte L. `ev_nbytes` equals L-14. Stream byte k is taken from lane k%WB of word `base_addr + k/WB`.
- R4: Records that start at any byte lane, and records that cross one or more word boundaries, are decoded the same way as aligned ones. Records are presented in stream order.
- R5: Payload byte j of a record appears on `ev_data[8*j+7:8*j]`. Every byte at an index of `ev_nbytes` or above is zero.
- R6: When a length byte of 0 is reached, `busy` returns to 0 and no further records are presented. A new `en_set` pulse starts a fresh run.
- R7: A length byte in 1..14 or 79..255 sets `err` and clears `busy`, and the record is not presented. `err` stays 1 until the next accepted `en_set`.
- R8: While `ev_valid` is 1 and `ev_ready` is 0, `ev_valid` stays 1 and all output fields keep their values on the following cycle.
- R9: Word requests stop once the holding buffer (WB+78 bytes) cannot take another word. With WB=64, `ev_ready` held low and 15-byte records, exactly two words are acknowledged, and `mem_req` then stays low.
- R10: An `en_set` pulse while `busy` is 1 is ignored. The fetch address and the record sequence carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en_set | input | 1 | Start pulse (the software write of 1 to the enable bit) |
| base_addr | input | AW | Word address of stream byte 0 |
| busy | output | 1 | Enable bit readback; cleared by the block at the end of the list |
| err | output | 1 | Sticky bad-length flag |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory word address |
| mem_ack | input | 1 | Read acknowledge; `mem_rdata` is valid in this cycle |
| mem_rdata | input | 8*WB | Memory read word |
| ev_valid | output | 1 | Decoded record available |
| ev_ready | input | 1 | Consumer accepts the record |
| ev_channel | output | 24 | Channel field |
| ev_time | output | 64 | Timestamp field |
| ev_addr | output | 16 | Address field |
| ev_data | output | 512 | Payload, zero above `ev_nbytes` bytes |
| ev_nbytes | output | 7 | Payload byte count, 1..64 |

## Verification
After the reset synchronizer lets go, an accepted start shows up on `busy` and `mem_addr` one cycle after the `en_set` edge. A word acknowledged on a rising edge can produce a record on `ev_valid` no sooner than the edge after that, because the length and fields are read from the registered buffer. The bench drives `ev_ready` and the acknowledge gate at the falling edge and samples at the same falling edge. A record seen there with `ev_valid` and `ev_ready` both high is therefore the one accepted at the next rising edge. A stall seen there is compared against the fields one falling edge later. End-of-list and error results are awaited with bounded polling, because the time the record stream takes depends on the acknowledge pattern.

// File: rtl/evrec_pkg.sv
package evrec_pkg;
  localparam int HDR_BYTES = 14;
  localparam int MIN_LEN   = HDR_BYTES + 1;
  localparam int MAX_PAY   = 64;
  localparam int MAX_LEN   = HDR_BYTES + MAX_PAY;
  localparam int PAY_W     = MAX_PAY * 8;
  localparam int CNT_W     = $clog2(MAX_PAY + 1);

  typedef struct packed {
    logic [23:0]      channel;
    logic [63:0]      stamp;
    logic [15:0]      target;
    logic [CNT_W-1:0] nbytes;
    logic [PAY_W-1:0] payload;
  } evrec_t;
endpackage

// File: rtl/evrec_bytebuf.sv
module evrec_bytebuf #(
  parameter int WB        = 64,
  parameter int BUF_BYTES = 142,
  parameter int POP_W     = 7,
  localparam int BW       = BUF_BYTES * 8,
  localparam int LW       = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [WB*8-1:0]  push_word,
  input  logic [POP_W-1:0] pop_n,
  output logic [LW-1:0]    level,
  output logic [BW-1:0]    bytes
);
  logic [LW-1:0] lvl_after, level_n;
  logic [BW-1:0] shifted, ins, msk, bytes_n;
  logic          bytes_en;

  always_comb begin
    lvl_after = level - LW'(pop_n);
    shifted   = bytes >> {pop_n, 3'b000};
    ins       = BW'(push_word) << {lvl_after, 3'b000};
    msk       = BW'({(WB*8){1'b1}}) << {lvl_after, 3'b000};
    bytes_n   = push ? ((shifted & ~msk) | ins) : shifted;
    bytes_en  = push || (pop_n != '0);
    if (clear) level_n = '0;
    else       level_n = lvl_after + (push ? LW'(WB) : LW'(0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else        level <= level_n;
  end

  always_ff @(posedge clk) begin
    if (bytes_en) bytes <= bytes_n;
  end
endmodule

// File: rtl/evrec_decode.sv
module evrec_decode
  import evrec_pkg::*;
(
  input  logic [MAX_LEN*8-1:0] win,
  output logic [7:0]           len,
  output logic                 is_end,
  output logic                 is_bad,
  output evrec_t               rec
);
  logic [PAY_W-1:0] raw;
  logic [7:0]       cnt8;

  assign len    = win[7:0];
  assign is_end = (len == 8'd0);
  assign is_bad = !is_end && ((len < 8'(MIN_LEN)) || (len > 8'(MAX_LEN)));
  assign cnt8   = len - 8'(HDR_BYTES);
  assign raw    = win[HDR_BYTES*8 +: PAY_W];

  assign rec.channel = win[31:8];
  assign rec.stamp   = win[95:32];
  assign rec.target  = win[111:96];
  assign rec.nbytes  = cnt8[CNT_W-1:0];

  for (genvar j = 0; j < MAX_PAY; j++) begin : g_lane
    assign rec.payload[j*8 +: 8] = (j < int'(cnt8)) ? raw[j*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/evrec_unpack.sv
module evrec_unpack
  import evrec_pkg::*;
#(
  parameter int WB = 64,
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_set,
  input  logic [AW-1:0]     base_addr,
  output logic              busy,
  output logic              err,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_ack,
  input  logic [WB*8-1:0]   mem_rdata,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [23:0]       ev_channel,
  output logic [63:0]       ev_time,
  output logic [15:0]       ev_addr,
  output logic [PAY_W-1:0]  ev_data,
  output logic [CNT_W-1:0]  ev_nbytes
);
  localparam int BUF_BYTES = WB + MAX_LEN;
  localparam int BW        = BUF_BYTES * 8;
  localparam int LW        = $clog2(BUF_BYTES + 1);
  localparam int POP_W     = $clog2(MAX_LEN + 1);

  logic [1:0]       rst_sync;
  logic             rst_i_n;
  logic [LW-1:0]    level;
  logic [BW-1:0]    bytes;
  logic [7:0]       len;
  logic             is_end, is_bad;
  evrec_t           rec, out_q;
  logic             start, stop, take, slot_free, have_len;
  logic [POP_W-1:0] pop_n;
  logic             busy_n, err_n, valid_n;
  logic [AW-1:0]    addr_n;

  // reset: asserted at once, released after two clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  evrec_bytebuf #(.WB(WB), .BUF_BYTES(BUF_BYTES), .POP_W(POP_W)) u_buf (
    .clk(clk), .rst_n(rst_i_n), .clear(start), .push(mem_ack),
    .push_word(mem_rdata), .pop_n(pop_n), .level(level), .bytes(bytes)
  );

  evrec_decode u_dec (
    .win(bytes[MAX_LEN*8-1:0]), .len(len), .is_end(is_end),
    .is_bad(is_bad), .rec(rec)
  );

  // next-state logic
  always_comb begin
    start     = en_set && !busy;
    have_len  = busy && (level != '0);
    slot_free = !ev_valid || ev_ready;
    stop      = have_len && (is_end || is_bad);
    take      = have_len && !is_end && !is_bad &&
                (int'(level) >= int'(len)) && slot_free;
    pop_n     = take ? len[POP_W-1:0] : '0;
    mem_req   = busy && (int'(level) <= BUF_BYTES - WB);

    busy_n = busy;
    if (start)     busy_n = 1'b1;
    else if (stop) busy_n = 1'b0;

    err_n = err;
    if (start)                err_n = 1'b0;
    else if (stop && is_bad)  err_n = 1'b1;

    addr_n = mem_addr;
    if (start)        addr_n = base_addr;
    else if (mem_ack) addr_n = mem_addr + AW'(1);

    valid_n = ev_valid;
    if (take)          valid_n = 1'b1;
    else if (ev_ready) valid_n = 1'b0;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      busy     <= 1'b0;
      err      <= 1'b0;
      ev_valid <= 1'b0;
      mem_addr <= '0;
    end else begin
      busy     <= busy_n;
      err      <= err_n;
      ev_valid <= valid_n;
      mem_addr <= addr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (take) out_q <= rec;
  end

  assign ev_channel = out_q.channel;
  assign ev_time    = out_q.stamp;
  assign ev_addr    = out_q.target;
  assign ev_data    = out_q.payload;
  assign ev_nbytes  = out_q.nbytes;
endmodule

// File: rtl/evrec_unpack_chk.sv
module evrec_unpack_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_set,
  input logic          busy,
  input logic          err,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          ev_valid,
  input logic          ev_ready,
  input logic [23:0]   ev_channel,
  input logic [63:0]   ev_time,
  input logic [15:0]   ev_addr,
  input logic [511:0]  ev_data,
  input logic [6:0]    ev_nbytes
);
  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (mem_addr == $past(mem_addr) + AW'(1))); // R2

  AST_NBYTES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_nbytes >= 7'd1 && ev_nbytes <= 7'd64)); // R3

  AST_PAYLOAD_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ((ev_data >> {ev_nbytes, 3'b000}) == '0)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !en_set) |=> err); // R7

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !en_set) |-> !busy); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_channel) &&
      $stable(ev_time) && $stable(ev_addr) && $stable(ev_data) &&
      $stable(ev_nbytes))); // R8

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && en_set && !mem_ack) |=> (mem_addr == $past(mem_addr))); // R10
endmodule

bind evrec_unpack evrec_unpack_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_set(en_set), .busy(busy), .err(err),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_channel(ev_channel),
  .ev_time(ev_time), .ev_addr(ev_addr), .ev_data(ev_data),
  .ev_nbytes(ev_nbytes)
);

// File: tb/sim_evrec_unpack.sv
module sim_evrec_unpack;
  localparam int CLK_PERIOD = 10;
  localparam int WB = 64;
  localparam int AW = 16;

  typedef struct packed {
    logic [23:0] ch;
    logic [63:0] ts;
    logic [15:0] ad;
    logic [6:0]  n;
    logic [7:0]  seed;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{24'h000001, 64'h0000_0000_0000_0023, 16'h0012, 7'd1,  8'h33},
    '{24'h000901, 64'h0000_0902_0000_0001, 16'h0911, 7'd64, 8'h88},
    '{24'h000081, 64'h0000_0000_0000_0288, 16'h0088, 7'd3,  8'h10},
    '{24'hABCDEF, 64'hFEDC_BA98_7654_3210, 16'hFFFF, 7'd17, 8'hA5},
    '{24'h7F0001, 64'h0000_0000_0000_0001, 16'h0000, 7'd50, 8'h01},
    '{24'h123456, 64'h8000_0000_0000_0000, 16'h8001, 7'd8,  8'hFE}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_set = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic busy, err, mem_req, mem_ack, ev_valid;
  logic ev_ready = 1'b0;
  logic ack_gate = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [WB*8-1:0] mem_rdata;
  logic [23:0] ev_channel;
  logic [63:0] ev_time;
  logic [15:0] ev_addr;
  logic [511:0] ev_data;
  logic [6:0] ev_nbytes;

  logic [WB*8-1:0] mem [0:63];
  int checks = 0;
  int errors = 0;

  logic [23:0]  e_ch [0:31];
  logic [63:0]  e_ts [0:31];
  logic [15:0]  e_ad [0:31];
  logic [6:0]   e_n  [0:31];
  logic [511:0] e_d  [0:31];
  bit           e_x  [0:31];
  int exp_total = 0;
  int rx_idx = 0;
  int wptr = 0;
  int ack_cnt = 0;
  bit hold_low = 1'b0;
  bit mon_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_ack   = mem_req & ack_gate;
  assign mem_rdata = mem[mem_addr[5:0]];

  evrec_unpack #(.WB(WB), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .en_set(en_set), .base_addr(base_addr),
    .busy(busy), .err(err), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_channel(ev_channel), .ev_time(ev_time),
    .ev_addr(ev_addr), .ev_data(ev_data), .ev_nbytes(ev_nbytes)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [511:0] pay(input logic [7:0] seed, input int n);
    logic [511:0] d = '0;
    for (int j = 0; j < n; j++) d[j*8 +: 8] = seed + 8'(j * 7);
    return d;
  endfunction

  task automatic put(input int a, input logic [7:0] b);
    mem[a / WB][(a % WB) * 8 +: 8] = b;
  endtask

  task automatic begin_stream(input int word);
    wptr = word * WB;
    exp_total = 0;
    rx_idx = 0;
  endtask

  task automatic add_rec(input vec_t v);
    int len = int'(v.n) + 14;
    logic [511:0] d = pay(v.seed, int'(v.n));
    e_x[exp_total] = ((wptr / WB) != ((wptr + len - 1) / WB));
    put(wptr, 8'(len));
    for (int i = 0; i < 3; i++) put(wptr + 1 + i, v.ch[i*8 +: 8]);
    for (int i = 0; i < 8; i++) put(wptr + 4 + i, v.ts[i*8 +: 8]);
    for (int i = 0; i < 2; i++) put(wptr + 12 + i, v.ad[i*8 +: 8]);
    for (int i = 0; i < int'(v.n); i++) put(wptr + 14 + i, d[i*8 +: 8]);
    e_ch[exp_total] = v.ch; e_ts[exp_total] = v.ts; e_ad[exp_total] = v.ad;
    e_n[exp_total] = v.n; e_d[exp_total] = d;
    exp_total++;
    wptr += len;
  endtask

  task automatic start(input int word);
    @(negedge clk);
    en_set = 1'b1;
    base_addr = AW'(word);
    @(negedge clk);
    en_set = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (!busy && rx_idx >= exp_total && !ev_valid) break;
      @(negedge clk);
    end
  endtask

  // monitor: update handshake drivers, then sample what the next edge sees
  logic [23:0] s_ch; logic [63:0] s_ts; logic [15:0] s_ad;
  logic [6:0] s_n; logic [511:0] s_d; bit s_stall = 1'b0;
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ev_ready = hold_low ? 1'b0 : (lfsr[0] | lfsr[3]);
    ack_gate = lfsr[5] | lfsr[8];
    if (mon_on) begin
      if (s_stall) begin  // R8 fields held across a stall
        chk(ev_valid == 1'b1, "R8 valid held", 64'(ev_valid), 64'd1);
        chk({ev_channel, ev_addr, ev_nbytes} == {s_ch, s_ad, s_n} &&
            ev_time == s_ts && ev_data == s_d, "R8 fields held",
            64'(ev_channel), 64'(s_ch));
      end
      if (mem_req && ack_gate) ack_cnt++;
      if (ev_valid && ev_ready) begin
        if (rx_idx >= exp_total) begin
          chk(1'b0, "R6 extra record", 64'(rx_idx), 64'(exp_total));
        end else begin
          chk(ev_channel == e_ch[rx_idx], e_x[rx_idx] ? "R4 channel" : "R3 channel",
              64'(ev_channel), 64'(e_ch[rx_idx]));
          chk(ev_time == e_ts[rx_idx], "R3 timestamp", ev_time, e_ts[rx_idx]);
          chk(ev_addr == e_ad[rx_idx], "R3 address", 64'(ev_addr), 64'(e_ad[rx_idx]));
          chk(ev_nbytes == e_n[rx_idx], "R3 nbytes", 64'(ev_nbytes), 64'(e_n[rx_idx]));
          chk(ev_data == e_d[rx_idx], e_x[rx_idx] ? "R4 R5 payload" : "R5 payload",
              ev_data[63:0], e_d[rx_idx][63:0]);
        end
        rx_idx++;
      end
      s_stall = ev_valid && !ev_ready;
      s_ch = ev_channel; s_ts = ev_time; s_ad = ev_addr; s_n = ev_nbytes; s_d = ev_data;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int w = 0; w < 64; w++) mem[w] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, err, ev_valid, mem_req} == 4'b0, "R1 in reset",
        64'({busy, err, ev_valid, mem_req}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, err, ev_valid, mem_req} == 4'b0, "R1 after release",
        64'({busy, err, ev_valid, mem_req}), 64'd0);
    mon_on = 1'b1;

    // table-driven main run: mixed lengths, records cross word lanes
    begin_stream(0);
    for (int i = 0; i < 6; i++) add_rec(TBL[i]);
    put(wptr, 8'h00);
    start(0);
    chk(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    chk(mem_addr == 16'd0, "R2 first address", 64'(mem_addr), 64'd0);
    // R10 start pulse while busy is ignored
    @(negedge clk);
    en_set = 1'b1; base_addr = 16'd40;
    @(negedge clk);
    en_set = 1'b0;
    chk(mem_addr < 16'd8, "R10 address kept", 64'(mem_addr), 64'd0);
    wait_done(2000);
    chk(rx_idx == 6, "R4 R10 record count", 64'(rx_idx), 64'd6);
    chk(busy == 1'b0, "R6 busy cleared at end", 64'(busy), 64'd0);
    chk(err == 1'b0, "R6 no error", 64'(err), 64'd0);
    repeat (10) @(negedge clk);
    chk(ev_valid == 1'b0 && rx_idx == 6, "R6 nothing after end",
        64'(rx_idx), 64'd6);

    // R9 fetch backpressure with ready held low
    hold_low = 1'b1;
    begin_stream(30);
    for (int i = 0; i < 20; i++)
      add_rec('{24'(i + 100), 64'(i * 3), 16'(i), 7'd1, 8'(i)});
    put(wptr, 8'h00);
    start(30);
    ack_cnt = 0;
    repeat (40) @(negedge clk);
    chk(ack_cnt == 1 || ack_cnt == 2, "R9 words fetched while stalled",
        64'(ack_cnt), 64'd2);
    chk(mem_req == 1'b0, "R9 requests stopped", 64'(mem_req), 64'd0);
    chk(ev_valid == 1'b1 && ev_channel == 24'd100, "R8 first record held",
        64'(ev_channel), 64'd100);
    hold_low = 1'b0;
    wait_done(3000);
    chk(rx_idx == 20, "R9 all records after release", 64'(rx_idx), 64'd20);

    // R7 bad length 9 after one good record
    begin_stream(40);
    add_rec('{24'h00AA55, 64'h55, 16'h77, 7'd2, 8'h44});
    put(wptr, 8'd9);
    start(40);
    wait_done(500);
    chk(err == 1'b1, "R7 err for length 9", 64'(err), 64'd1);
    chk(busy == 1'b0 && rx_idx == 1, "R7 stopped after bad length",
        64'(rx_idx), 64'd1);
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R7 err sticky", 64'(err), 64'd1);

    // R2 restart clears err; R6 immediate terminator
    begin_stream(50);
    start(50);
    chk(err == 1'b0 && busy == 1'b1, "R2 R7 restart clears err",
        64'({err, busy}), 64'b01);
    wait_done(100);
    chk(busy == 1'b0 && rx_idx == 0, "R6 empty list", 64'(rx_idx), 64'd0);

    // R7 length 79 is one above the largest legal record
    begin_stream(44);
    put(wptr, 8'd79);
    start(44);
    wait_done(100);
    chk(err == 1'b1 && busy == 1'b0 && rx_idx == 0, "R7 length 79",
        64'({err, busy}), 64'b10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule